// File: doc/BRIEF.md
# Byte-Wide Indirect Coefficient Memory Port

This block connects a narrow processor bus (8-bit data, 3-bit address) to internal memories whose words are 72 bits wide. A write never reaches a memory directly. The processor first places up to three bytes in a 24-bit staging register. It then issues an update strobe. Each strobe copies the staging register into one 24-bit section of a word buffer, and a section counter advances. On the third strobe the buffer holds a complete word. On the next cycle that word is written, with a single-cycle write enable, to the location held in the 8-bit address register.

Readback is byte-serial. A byte counter picks one byte of the word that the addressed memory presents. One register write clears the counter and another advances it, so the processor must issue a write between successive byte reads.

A select register picks between the writable coefficient memory and a second memory that can only be read through this port. A completed word is never written into the read-only memory.

Top module: `imp_top`

## Requirements
- R1: After reset, `memWe` is 0, `memAddr` is 0 and `memSel` is 0, and both the section counter and the byte counter are 0.
- R2: A bus write to address 0, 1 or 2 loads `busWdata` into bits [7:0], [15:8] or [23:16] of the staging register respectively, leaving its other bits unchanged.
- R3: A bus write to address 5 (update strobe, data ignored) copies the staging register into buffer section k, where k is the section counter. Section k occupies bits [24k+23:24k] of `memWdata`. The strobe then advances the counter.
- R4: The strobe that fills section 2 returns the section counter to 0. In the following cycle, and only then, `memWe` is 1 for exactly one cycle. During that cycle `memWdata` holds the assembled word and `memAddr` holds the address last written at bus address 3.
- R5: Bit 0 of a write to address 4 drives `memSel` (0 selects the writable memory, 1 selects the read-only memory). A completing strobe made while `memSel` is 1 produces no `memWe` pulse, but the section counter still returns to 0.
- R6: A bus write to address 6 clears the byte counter to 0.
- R7: A bus write to address 7 increments the byte counter, which wraps from 15 to 0.
- R8: While `busRd` is 1, `busRdata` equals bits [8n+7:8n] of `memRdata`, where n is the byte counter, for n from 0 to 8. For n from 9 to 15 it is 0.
- R9: While `busRd` is 0, `busRdata` is 0, and reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Bus write pulse, one cycle per write |
| busRd | input | 1 | Bus read enable |
| busAddr | input | 3 | Bus register address |
| busWdata | input | 8 | Bus write data |
| busRdata | output | 8 | Bus read data |
| memWe | output | 1 | Memory write enable, single-cycle |
| memAddr | output | 8 | Memory word address |
| memSel | output | 1 | Memory select (1 = read-only memory) |
| memWdata | output | 72 | Assembled word to write |
| memRdata | input | 72 | Word read from the selected memory at `memAddr` |

## Verification
The assertions assume that every `busWr` is a one-cycle request whose address and data are stable at the clock edge. They also assume that `memRdata` is a combinational function of `memAddr` and `memSel`, as the external memory model in the bench provides. The stimulus drives each bus write for exactly one cycle, changing inputs on the falling edge. It never issues a write and a read of state in the same cycle. Readback is compared against a memory model in the bench, and the read-only memory's contents are computed there from the address.

// File: rtl/imp_pkg.sv
package imp_pkg;
  localparam int BYTE_W   = 8;
  localparam int SECT_W   = 24;
  localparam int SECTIONS = 3;
  localparam int SECT_IDX_W = 2;

  localparam logic [2:0] ADR_STAGE0 = 3'd0;
  localparam logic [2:0] ADR_STAGE1 = 3'd1;
  localparam logic [2:0] ADR_STAGE2 = 3'd2;
  localparam logic [2:0] ADR_WADDR  = 3'd3;
  localparam logic [2:0] ADR_SEL    = 3'd4;
  localparam logic [2:0] ADR_UPDATE = 3'd5;
  localparam logic [2:0] ADR_BCLR   = 3'd6;
  localparam logic [2:0] ADR_BINC   = 3'd7;

  typedef struct packed {
    logic [SECT_W/BYTE_W-1:0] loadStage;
    logic                     loadAddr;
    logic                     loadSel;
    logic                     capture;
    logic [SECT_IDX_W-1:0]    section;
  } strobe_t;
endpackage

// File: rtl/imp_ctrl.sv
module imp_ctrl
  import imp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [2:0]       busAddr,
  input  logic             selRo,
  output strobe_t          stb,
  output logic             memWe,
  output logic [CNT_W-1:0] byteCnt
);
  localparam logic [SECT_IDX_W-1:0] LAST_SECT = SECT_IDX_W'(SECTIONS - 1);

  logic [SECT_IDX_W-1:0] wordSel;
  logic lastSect;
  logic clrByte, incByte;

  assign lastSect = (wordSel == LAST_SECT);
  assign clrByte  = busWr && (busAddr == ADR_BCLR);
  assign incByte  = busWr && (busAddr == ADR_BINC);

  always_comb begin
    stb = '0;
    stb.section = wordSel;
    if (busWr) begin
      unique case (busAddr)
        ADR_STAGE0: stb.loadStage[0] = 1'b1;
        ADR_STAGE1: stb.loadStage[1] = 1'b1;
        ADR_STAGE2: stb.loadStage[2] = 1'b1;
        ADR_WADDR:  stb.loadAddr = 1'b1;
        ADR_SEL:    stb.loadSel = 1'b1;
        ADR_UPDATE: stb.capture = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordSel <= '0;
      memWe   <= 1'b0;
      byteCnt <= '0;
    end else begin
      memWe <= stb.capture && lastSect && !selRo;
      if (stb.capture) wordSel <= lastSect ? '0 : wordSel + 1'b1;
      if (clrByte)      byteCnt <= '0;
      else if (incByte) byteCnt <= byteCnt + 1'b1;
    end
  end

  p_we_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && lastSect) |=> (wordSel == '0));
  p_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && !lastSect) |=> (wordSel == $past(wordSel) + 1'b1));
  p_ro_no_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && selRo) |=> !memWe);
  p_byte_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    clrByte |=> (byteCnt == '0));
  p_byte_inc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (incByte && !clrByte) |=> (byteCnt == $past(byteCnt) + 1'b1));
endmodule

// File: rtl/imp_datapath.sv
module imp_datapath
  import imp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4,
  localparam int WORD_W = SECT_W * SECTIONS,
  localparam int WORD_BYTES = WORD_W / BYTE_W,
  localparam int STAGE_BYTES = SECT_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] busWdata,
  input  logic              busRd,
  input  logic [CNT_W-1:0]  byteCnt,
  input  logic [WORD_W-1:0] memRdata,
  output logic [BYTE_W-1:0] busRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSel,
  output logic [WORD_W-1:0] memWdata
);
  logic [SECT_W-1:0] stageReg;
  logic [SECT_W-1:0] bufSect [SECTIONS];

  for (genvar b = 0; b < STAGE_BYTES; b++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stageReg[b*BYTE_W +: BYTE_W] <= '0;
      else if (stb.loadStage[b]) stageReg[b*BYTE_W +: BYTE_W] <= busWdata;
    end
  end

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sect
    always_ff @(posedge clk) begin
      if (!rstN) bufSect[s] <= '0;
      else if (stb.capture && stb.section == SECT_IDX_W'(s)) bufSect[s] <= stageReg;
    end
    assign memWdata[s*SECT_W +: SECT_W] = bufSect[s];

    p_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
      (stb.capture && stb.section == SECT_IDX_W'(s)) |=> (bufSect[s] == $past(stageReg)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      memSel  <= 1'b0;
    end else begin
      if (stb.loadAddr) memAddr <= busWdata[ADDR_W-1:0];
      if (stb.loadSel)  memSel  <= busWdata[0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      for (int i = 0; i < WORD_BYTES; i++) begin
        if (byteCnt == CNT_W'(i)) busRdata = memRdata[i*BYTE_W +: BYTE_W];
      end
    end
  end

  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadStage == '0) |=> $stable(stageReg));
endmodule

// File: rtl/imp_top.sv
module imp_top
  import imp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4,
  localparam int WORD_W = SECT_W * SECTIONS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [2:0]        busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSel,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata
);
  strobe_t stb;
  logic [CNT_W-1:0] byteCnt;

  imp_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .selRo(memSel), .stb(stb), .memWe(memWe), .byteCnt(byteCnt)
  );

  imp_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata), .busRd(busRd),
    .byteCnt(byteCnt), .memRdata(memRdata), .busRdata(busRdata),
    .memAddr(memAddr), .memSel(memSel), .memWdata(memWdata)
  );

  p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> (busRdata == '0));
endmodule

// File: tb/imp_top_tb_top.sv
module imp_top_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic memWe, memSel;
  logic [7:0] memAddr;
  logic [71:0] memWdata, memRdata;

  logic [71:0] ram [256];
  int nChecks = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imp_top dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .memWe(memWe), .memAddr(memAddr),
    .memSel(memSel), .memWdata(memWdata), .memRdata(memRdata)
  );

  function automatic logic [71:0] romWord(input logic [7:0] a);
    logic [71:0] w;
    for (int i = 0; i < 9; i++) w[i*8 +: 8] = a ^ 8'(8'h30 + i);
    return w;
  endfunction

  always_ff @(posedge clk) if (memWe) ram[memAddr] <= memWdata;
  always_comb memRdata = memSel ? romWord(memAddr) : ram[memAddr];

  localparam logic [79:0] VEC [4] = '{
    {8'h00, 72'h0123456789ABCDEF11},
    {8'hFF, 72'hFEDCBA98765432100F},
    {8'h12, 72'hA5A5A5_5A5A5A_C3C3C3},
    {8'h80, 72'h000001_800000_FFFFFF}
  };

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic loadWord(input logic [71:0] w);
    for (int s = 0; s < 3; s++) begin
      busWrite(3'd0, w[s*24 +: 8]);
      busWrite(3'd1, w[s*24+8 +: 8]);
      busWrite(3'd2, w[s*24+16 +: 8]);
      busWrite(3'd5, 8'h00);
    end
  endtask

  task automatic readBack(input string tag, input logic [71:0] exp);
    busWrite(3'd6, 8'h00);
    for (int b = 0; b < 9; b++) begin
      busRd = 1'b1; #1;
      check(tag, busRdata, exp[b*8 +: 8]);
      busRd = 1'b0;
      busWrite(3'd7, 8'h00);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 memWe", memWe, 0);
    check("R1 memAddr", memAddr, 0);
    check("R1 memSel", memSel, 0);
    rstN = 1'b1;
    @(negedge clk);
    ram[0] = 72'h99_8877_6655_4433_2211;
    busRd = 1'b1; #1;
    check("R1 byte counter zero", busRdata, 8'h11);
    busRd = 1'b0; #1;
    check("R9 idle read data", busRdata, 0);

    // table of words: write, verify pulse, read back
    foreach (VEC[k]) begin
      logic [7:0] a; logic [71:0] w;
      a = VEC[k][79:72]; w = VEC[k][71:0];
      busWrite(3'd3, a);
      loadWord(w);
      check("R4 pulse", memWe, 1);
      check("R3 assembled word", memWdata, w);
      check("R4 address", memAddr, a);
      @(negedge clk);
      check("R4 single pulse", memWe, 0);
      readBack("R8 readback", w);
    end

    // R2: single staging byte update keeps other bytes
    busWrite(3'd3, 8'h40);
    loadWord(72'h111111_222222_333333);
    @(negedge clk);
    busWrite(3'd1, 8'hEE);
    busWrite(3'd5, 8'h00);
    busWrite(3'd5, 8'h00);
    busWrite(3'd5, 8'h00);
    check("R2 partial staging", memWdata, 72'h11EE11_11EE11_11EE11);
    check("R4 pulse after partial", memWe, 1);

    // R3: no pulse after only two strobes
    busWrite(3'd5, 8'h00);
    busWrite(3'd5, 8'h00);
    check("R3 no early pulse", memWe, 0);
    busWrite(3'd5, 8'h00);
    check("R4 pulse on third", memWe, 1);

    // R8: bytes beyond 8 read zero, wrap after 15 (R7)
    busWrite(3'd3, 8'h00);
    busWrite(3'd6, 8'h00);
    for (int b = 0; b < 9; b++) busWrite(3'd7, 8'h00);
    for (int b = 9; b < 16; b++) begin
      busRd = 1'b1; #1;
      check("R8 high byte zero", busRdata, 0);
      busRd = 1'b0;
      busWrite(3'd7, 8'h00);
    end
    busRd = 1'b1; #1;
    check("R7 wrap to byte 0", busRdata, ram[0][7:0]);
    busRd = 1'b0;
    // R6: clear from mid count
    busWrite(3'd7, 8'h00);
    busWrite(3'd6, 8'h00);
    busRd = 1'b1; #1;
    check("R6 clear", busRdata, ram[0][7:0]);
    busRd = 1'b0;

    // R5: read-only memory readback and suppressed write
    busWrite(3'd3, 8'h12);
    busWrite(3'd4, 8'h01);
    check("R5 select", memSel, 1);
    readBack("R5 rom readback", romWord(8'h12));
    loadWord(72'hDEADBEEF_0000_1234_56);
    check("R5 no write pulse", memWe, 0);
    @(negedge clk);
    check("R5 still no pulse", memWe, 0);
    busWrite(3'd4, 8'h00);
    readBack("R5 ram untouched", VEC[2][71:0]);
    busWrite(3'd5, 8'h00);
    busWrite(3'd5, 8'h00);
    check("R5 counter wrapped", memWe, 0);
    busWrite(3'd5, 8'h00);
    check("R5 pulse after wrap", memWe, 1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule